// File: doc/BRIEF.md
# Switchable-Depth UART Receive Queue

This block holds received UART characters until software reads them through the data register. Each entry carries eight data bits and four line-status bits. The status bits are framing error in bit 8, parity error in bit 9, break in bit 10 and overrun in bit 11. The deserializer offers one entry per cycle on a push port. It may only hand over an entry while `can_accept` is high. A data-register read drives the pop port. The oldest entry is shown combinationally on `pop_data` and is removed at the clock edge.

A control input selects the queue mode. When `fifo_en` is high, the queue uses its full power-of-two depth (16 by default). When `fifo_en` is low, it collapses to a single holding register. Any change of `fifo_en` discards everything queued.

On every pop, the four status bits of the entry being read are latched into a receive-status register. Software clears that register with `stat_clr`. The interrupt controller is driven by two one-cycle pulses. One requests the receive interrupt when the queue stops being empty. The other withdraws it when a read drains the last entry.

Top module: `uart_rxq`

## Requirements
- R1: With `fifo_en` = 1 the queue holds DEPTH entries, and with `fifo_en` = 0 it holds exactly 1. `full` is high when the occupancy equals that effective depth, and `can_accept` is high only while the occupancy is below it.
- R2: Entries leave in the order they were accepted, including after the read position wraps past the last slot.
- R3: A push offered while the queue is full is dropped and changes nothing.
- R4: `irq_set` pulses for one cycle, in the cycle after a push that takes the occupancy from 0 to 1. `irq_clr` pulses for one cycle, in the cycle after a pop that takes it from 1 to 0. The two never pulse together.
- R5: While the queue is not empty, `pop_data` shows the oldest entry. A pop removes that entry and leaves `full` low.
- R6: Every pop copies bits 11:8 of the entry on `pop_data` into `rx_status`. `stat_clr` zeroes `rx_status` and wins over a pop in the same cycle.
- R7: A pop on an empty queue leaves the occupancy, the read position and the flags unchanged, and raises no interrupt request. `pop_data` keeps showing the slot at the read position, and that slot is still captured into `rx_status`.
- R8: In a cycle where `fifo_en` differs from the mode in use, the queue is emptied and `full` is cleared. A push or pop offered in that same cycle is ignored. The new depth applies from the next cycle.
- R9: An entry is laid out as data in bits 7:0, framing in bit 8, parity in bit 9, break in bit 10 and overrun in bit 11. A break arrives as 12'h400.
- R10: A push and a pop in the same cycle on a non-empty, non-full queue both take effect. The occupancy is unchanged and no interrupt request is raised.
- R11: After reset the queue is empty, not full, in single-entry mode, with `rx_status` zero and no interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = full depth, 0 = single holding register |
| push_valid | input | 1 | Deserializer offers an entry |
| push_data | input | 12 | Offered entry (status in 11:8, data in 7:0) |
| can_accept | output | 1 | Queue has room at the current depth |
| pop | input | 1 | Data-register read strobe |
| pop_data | output | 12 | Entry at the read position |
| stat_clr | input | 1 | Write to the receive-status register (clears it) |
| rx_status | output | 4 | Status bits of the last popped entry |
| empty | output | 1 | No entry held |
| full | output | 1 | Occupancy equals effective depth |
| irq_set | output | 1 | One-cycle request to raise the receive interrupt |
| irq_clr | output | 1 | One-cycle request to withdraw the receive interrupt |

## Verification
A wrong occupancy shows up within one cycle at the ports. It appears as `full` or `can_accept` at the wrong fill level, or as `empty` staying high after an accepted push. A corrupt read position or write slot stays hidden until the affected entry reaches the head. It then shows as a data or status mismatch on `pop_data` or `rx_status`. The scoreboard therefore drains each fill completely, including after the read position wraps. A missed flush on a mode change shows up as stale entries, or as `full` set at the wrong level, on the first access after the change.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DATA_W  = 8;
  localparam int RXQ_STAT_W  = 4;
  localparam int RXQ_ENTRY_W = RXQ_DATA_W + RXQ_STAT_W;
  // Status bit positions inside an entry (decoded by software via rx_status)
  localparam int RXQ_FRAME_BIT = 8;
  localparam int RXQ_PARITY_BIT = 9;
  localparam int RXQ_BREAK_BIT = 10;
  localparam int RXQ_OVRUN_BIT = 11;

  typedef logic [RXQ_ENTRY_W-1:0] rxq_entry_t;
  typedef logic [RXQ_STAT_W-1:0]  rxq_stat_t;
endpackage

// File: rtl/rxq_ctrl.sv
// Occupancy, read position and mode tracking for the receive queue.
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             push_valid,
  input  logic             pop,
  output logic             can_accept,
  output logic             empty,
  output logic             full,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_slot,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             pop_seen,
  output logic             set_ev,
  output logic             clr_ev
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
  localparam logic [PTR_W-1:0] WRAP_MSK = PTR_W'(DEPTH - 1);

  logic             fen_q, fen_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic [CNT_W-1:0] eff_depth;
  logic [PTR_W-1:0] slot_msk;
  logic             mode_chg, push_ok, pop_ok;

  always_comb begin
    eff_depth  = fen_q ? FULL_CNT : ONE_CNT;
    slot_msk   = fen_q ? WRAP_MSK : '0;
    mode_chg   = (fifo_en != fen_q);
    can_accept = (cnt_q < eff_depth);
    push_ok    = push_valid && can_accept && !mode_chg;
    pop_ok     = pop && (cnt_q != '0) && !mode_chg;
    pop_seen   = pop && !mode_chg;
    wr_en      = push_ok;
    wr_slot    = (rptr_q + cnt_q[PTR_W-1:0]) & slot_msk;
    set_ev     = push_ok && (cnt_q == '0);
    clr_ev     = pop_ok && !push_ok && (cnt_q == ONE_CNT);
    empty      = (cnt_q == '0);
    full       = (cnt_q == eff_depth);
    rd_ptr     = rptr_q;

    fen_d  = fifo_en;
    cnt_d  = cnt_q;
    rptr_d = rptr_q;
    if (mode_chg) begin
      cnt_d  = '0;
      rptr_d = '0;
    end else begin
      if (push_ok && !pop_ok) cnt_d = cnt_q + ONE_CNT;
      if (pop_ok && !push_ok) cnt_d = cnt_q - ONE_CNT;
      if (pop_ok) rptr_d = (rptr_q + PTR_W'(1)) & slot_msk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q  <= 1'b0;
      cnt_q  <= '0;
      rptr_q <= '0;
    end else begin
      fen_q  <= fen_d;
      cnt_q  <= cnt_d;
      rptr_q <= rptr_d;
    end
  end
endmodule

// File: rtl/rxq_store.sv
// Entry storage: one register per slot, single write port, one read port.
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_slot,
  input  rxq_entry_t       wr_data,
  input  logic [PTR_W-1:0] rd_slot,
  output rxq_entry_t       rd_data
);
  rxq_entry_t cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rxq_entry_t cell_q;
    logic       cell_we;
    assign cell_we = wr_en && (wr_slot == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (cell_we) cell_q <= wr_data;
    end
    assign cells[g] = cell_q;
  end

  assign rd_data = cells[rd_slot];
endmodule

// File: rtl/rxq_flags.sv
// Receive-status register and registered interrupt request pulses.
module rxq_flags
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pop_seen,
  input  logic       stat_clr,
  input  rxq_entry_t head,
  input  logic       set_ev,
  input  logic       clr_ev,
  output rxq_stat_t  rx_status,
  output logic       irq_set,
  output logic       irq_clr
);
  rxq_stat_t stat_q, stat_d;
  logic      set_q, clr_q;

  always_comb begin
    stat_d = stat_q;
    if (stat_clr)      stat_d = '0;
    else if (pop_seen) stat_d = head[RXQ_ENTRY_W-1:RXQ_DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      set_q  <= set_ev;
      clr_q  <= clr_ev;
    end
  end

  assign rx_status = stat_q;
  assign irq_set   = set_q;
  assign irq_clr   = clr_q;
endmodule

// File: rtl/uart_rxq.sv
// Switchable-depth UART receive queue (DEPTH must be a power of two, >= 2).
module uart_rxq
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fifo_en,
  input  logic        push_valid,
  input  logic [11:0] push_data,
  output logic        can_accept,
  input  logic        pop,
  output logic [11:0] pop_data,
  input  logic        stat_clr,
  output logic [3:0]  rx_status,
  output logic        empty,
  output logic        full,
  output logic        irq_set,
  output logic        irq_clr
);
  localparam int PTR_W = $clog2(DEPTH);

  logic             wr_en, pop_seen, set_ev, clr_ev;
  logic [PTR_W-1:0] wr_slot, rd_ptr;
  rxq_entry_t       head;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .push_valid(push_valid), .pop(pop),
    .can_accept(can_accept), .empty(empty), .full(full),
    .wr_en(wr_en), .wr_slot(wr_slot), .rd_ptr(rd_ptr),
    .pop_seen(pop_seen), .set_ev(set_ev), .clr_ev(clr_ev)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(push_data),
    .rd_slot(rd_ptr), .rd_data(head)
  );

  rxq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .pop_seen(pop_seen), .stat_clr(stat_clr),
    .head(head), .set_ev(set_ev), .clr_ev(clr_ev),
    .rx_status(rx_status), .irq_set(irq_set), .irq_clr(irq_clr)
  );

  assign pop_data = head;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       push_valid,
  input logic       can_accept,
  input logic       pop,
  input logic       stat_clr,
  input logic [3:0] rx_status,
  input logic       empty,
  input logic       full,
  input logic       irq_set,
  input logic       irq_clr
);
  logic mode_seen;
  logic chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_seen <= 1'b0;
    else        mode_seen <= fifo_en;
  end
  assign chg = (fifo_en != mode_seen);

  // R1
  single_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_seen && !chg && !empty) |-> full);

  // R2
  push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && can_accept && !chg) |=> !empty);

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !pop && !chg) |=> full);

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && $past(empty) && $past(rst_n)) |-> irq_set);

  // R4
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_set && irq_clr));

  // R5
  pop_unfull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push_valid && !chg) |=> !full);

  // R6
  stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (rx_status == 4'h0));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push_valid && !chg) |=> (empty && !irq_clr));

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (empty && !full));
endmodule

bind uart_rxq uart_rxq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
  .can_accept(can_accept), .pop(pop), .stat_clr(stat_clr),
  .rx_status(rx_status), .empty(empty), .full(full),
  .irq_set(irq_set), .irq_clr(irq_clr)
);

// File: tb/uart_rxq_bench.sv
module uart_rxq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fifo_en, push_valid, pop, stat_clr;
  logic [11:0] push_data;
  logic        can_accept, empty, full, irq_set, irq_clr;
  logic [11:0] pop_data;
  logic [3:0]  rx_status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mdl_mode = 1'b0;
  logic [11:0] exp_q[$];

  always #5 clk = ~clk;

  uart_rxq u_uart_rxq (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
    .push_data(push_data), .can_accept(can_accept), .pop(pop),
    .pop_data(pop_data), .stat_clr(stat_clr), .rx_status(rx_status),
    .empty(empty), .full(full), .irq_set(irq_set), .irq_clr(irq_clr)
  );

  function automatic int eff();
    return mdl_mode ? 16 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Driver: offer one entry; scoreboard records it when room is expected (R1, R3, R4)
  task automatic do_push(input logic [11:0] d);
    bit acc;
    acc = (exp_q.size() < eff());
    chk(can_accept == acc, "R1", "can_accept", int'(can_accept), int'(acc));
    push_valid = 1'b1; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
    if (acc) exp_q.push_back(d);
    chk(irq_set == (acc && exp_q.size() == 1), "R4", "irq_set",
        int'(irq_set), int'(acc && exp_q.size() == 1));
    chk(full == (exp_q.size() == eff()), "R3", "full", int'(full),
        int'(exp_q.size() == eff()));
    chk(empty == (exp_q.size() == 0), "R2", "empty", int'(empty),
        int'(exp_q.size() == 0));
  endtask

  // Monitor side: compare the head with the scoreboard and retire it (R2, R5, R6)
  task automatic do_pop();
    logic [11:0] v;
    v = exp_q[0];
    chk(pop_data == v, "R2", "pop_data", int'(pop_data), int'(v));
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    void'(exp_q.pop_front());
    chk(rx_status == v[11:8], "R6", "rx_status", int'(rx_status), int'(v[11:8]));
    chk(irq_clr == (exp_q.size() == 0), "R4", "irq_clr", int'(irq_clr),
        int'(exp_q.size() == 0));
    chk(!full, "R5", "full after pop", int'(full), 0);
    chk(empty == (exp_q.size() == 0), "R5", "empty", int'(empty),
        int'(exp_q.size() == 0));
  endtask

  // R10: simultaneous push and pop
  task automatic do_push_pop(input logic [11:0] d);
    logic [11:0] v;
    v = exp_q[0];
    chk(pop_data == v, "R10", "pop_data", int'(pop_data), int'(v));
    push_valid = 1'b1; push_data = d; pop = 1'b1;
    @(negedge clk);
    push_valid = 1'b0; pop = 1'b0;
    void'(exp_q.pop_front());
    exp_q.push_back(d);
    chk(!irq_set && !irq_clr, "R10", "irq pulses", int'({irq_set, irq_clr}), 0);
    chk(!empty, "R10", "empty", int'(empty), 0);
  endtask

  task automatic set_mode(input bit m);
    fifo_en = m;
    @(negedge clk);
    if (m != mdl_mode) exp_q.delete();
    mdl_mode = m;
    chk(empty && !full, "R8", "flags after mode change", int'({empty, full}), 2);
  endtask

  task automatic clr_status();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk(rx_status == 4'h0, "R6", "rx_status after clear", int'(rx_status), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; push_valid = 1'b0; pop = 1'b0;
    stat_clr = 1'b0; push_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(empty && !full && can_accept, "R11", "flags", int'({empty, full, can_accept}), 5);
    chk(rx_status == 4'h0 && !irq_set && !irq_clr, "R11", "status/irq",
        int'({rx_status, irq_set, irq_clr}), 0);

    // Single-entry mode: R1, R3, R7
    do_push(12'h3A5);
    chk(full && !can_accept, "R1", "single-mode full", int'({full, can_accept}), 2);
    do_push(12'h05A); // R3: dropped
    do_pop();
    clr_status();
    // R7: pop on empty shows stale slot and still captures status
    chk(pop_data == 12'h3A5, "R7", "stale pop_data", int'(pop_data), 12'h3A5);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    chk(empty && !full && !irq_clr, "R7", "state after empty pop",
        int'({empty, full, irq_clr}), 4);
    chk(rx_status == 4'h3, "R7", "status from stale slot", int'(rx_status), 3);
    chk(can_accept, "R7", "can_accept", int'(can_accept), 1);

    // Full-depth mode with wrap: R1, R2, R3, R10
    set_mode(1'b1);
    for (int i = 0; i < 16; i++) do_push(12'h010 + 12'(i));
    chk(full && !can_accept, "R1", "fifo full at 16", int'({full, can_accept}), 2);
    do_push(12'h7FF); // R3: dropped
    for (int i = 0; i < 10; i++) do_pop();
    for (int i = 0; i < 8; i++) do_push(12'h820 + 12'(i));
    do_push_pop(12'h930);
    do_push_pop(12'hA31);
    while (exp_q.size() > 0) do_pop();

    // R6: clear wins over a pop in the same cycle
    do_push(12'h1FF);
    stat_clr = 1'b1; pop = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0; pop = 1'b0;
    void'(exp_q.pop_front());
    chk(rx_status == 4'h0, "R6", "clear priority", int'(rx_status), 0);
    chk(empty, "R6", "entry removed", int'(empty), 1);

    // R9: break entry
    do_push(12'h400);
    chk(pop_data[7:0] == 8'h00 && pop_data[10], "R9", "break layout", int'(pop_data), 12'h400);
    do_pop();
    chk(rx_status == 4'b0100, "R9", "break status bit", int'(rx_status), 4);

    // R8: flush on mode change, push in that cycle ignored
    do_push(12'h101); do_push(12'h102); do_push(12'h103);
    set_mode(1'b0);
    do_push(12'h0C1);
    chk(full, "R8", "depth 1 after switch", int'(full), 1);
    do_pop();
    fifo_en = 1'b1; push_valid = 1'b1; push_data = 12'h0EE;
    @(negedge clk);
    push_valid = 1'b0;
    mdl_mode = 1'b1; exp_q.delete();
    chk(empty && !irq_set, "R8", "push during change ignored", int'({empty, irq_set}), 2);
    do_push(12'h0D2); do_push(12'h0D3);
    chk(!full, "R8", "full depth restored", int'(full), 0);
    do_pop(); do_pop();

    finish_run();
  end
endmodule